// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block takes eight 24-bit audio samples per frame and sends them out on four serial data lines, one stereo pair per line, alongside four user-bit lines. It runs from a master clock at 256 times the sample rate. From that clock it makes its own bit clock at 64 times the sample rate and its own word clock at the sample rate. A frame is 256 master clock cycles, split into a left half and a right half of 32 bit slots each.

Upstream logic offers a new set of samples and user bits with a one-cycle strobe at any point in a frame. The formatter keeps the most recent offer. It moves that offer into its output registers only at the next frame boundary, so a frame that is already being sent is never mixed with new data. A two-bit format input picks one of three framings: left-justified, right-justified with sign extension, or left-justified with a gated bit clock. The fourth code value stops the block. A mute input zeroes the data lines and leaves both clocks running.

Top module: `sfmt_top`

## Requirements
- R1: The bit clock has a period of 4 master clock cycles with 2 cycles high and 2 low in formats 00 and 01. A frame, measured from one rising word clock edge to the next, is 256 master clock cycles.
- R2: The word clock is high for the 32 slots of the left half and low for the 32 slots of the right half. Line k carries sample 2k in the left half and sample 2k+1 in the right half. Sample n occupies bits [24n+23:24n] of the sample bus.
- R3: With format 00, the bit clock is low for the first two master cycles of every slot. Its falling edge therefore lines up with each word clock transition.
- R4: With format 10, the word clock, bit clock, data lines and user lines are all held low from the cycle after the code is applied. When the code is removed, the word clock goes high on the next cycle and a new left half begins.
- R5: With format 01, the bit clock is high for the first two master cycles of every slot. Slot s (0 to 23) of each half carries bit 23-s of the word, MSB first, and slots 24 to 31 carry 0.
- R6: With format 00, slots 0 to 7 of each half carry bit 23 (sign extension) and slot s (8 to 31) carries bit 31-s.
- R7: With format 11, the bit clock is high for the first two master cycles of slots 0 to 23 only and low for the rest of each half. The data follow R5.
- R8: When mute is high, every data line is 0 from the next cycle on, while the word clock and bit clock continue as in R1 to R3.
- R9: A strobe captures the sample bus and user bits. The last capture before a frame starts is sent in that frame. A strobe during a frame does not change the frame in progress.
- R10: User line i carries user bit i of the frame's capture. It changes only with the rising word clock edge and stays constant for the whole frame.
- R11: While the asynchronous reset input is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock, 256 x sample rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_stb_i | input | 1 | Capture strobe for samples and user bits |
| sample_i | input | 192 | Eight 24-bit samples, sample n at [24n+23:24n] |
| user_i | input | 4 | User bits for the next frame |
| fmt_i | input | 2 | 00 right-justified, 01 left-justified, 10 stop, 11 gated bit clock |
| mute_i | input | 1 | Forces data lines to zero |
| wclk_o | output | 1 | Word clock, high for the left half |
| bclk_o | output | 1 | Bit clock |
| sdata_o | output | 4 | Serial data, line k carries pair k |
| user_o | output | 4 | User-bit lines |

## Verification
Every output comes from a register that is computed from the frame counter. Each output therefore appears one master cycle after the counter reaches a given position, and the first cycle in which the word clock is high counts as cycle 0 of the frame. The data, word clock and user checks sample at cycle 4k+1 of slot k. The bit clock checks sample at 4k+1 and 4k+2. All samples are taken on the falling master clock edge. Changes to the format, to mute and to the strobe are made at fixed cycles inside a frame, so each frame in the scoreboard runs under a single setting. Mute, the stop code and the effect of leaving the stop code are all checked one cycle after the input changes.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

  typedef enum logic [1:0] {
    FMT_RJ    = 2'b00,
    FMT_LJ    = 2'b01,
    FMT_STOP  = 2'b10,
    FMT_GATED = 2'b11
  } fmt_e;

endpackage

// File: rtl/sfmt_rst_sync.sv
module sfmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/sfmt_timing.sv
module sfmt_timing
  import sfmt_pkg::*;
#(
  parameter int SLOTS        = 32,
  parameter int MCLK_PER_BIT = 4,
  parameter int SAMPLE_W     = 24,
  parameter int SLOT_W       = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fmt_e              fmt_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              half_o,
  output logic              frame_start_o,
  output logic              load_o,
  output logic              wclk_o,
  output logic              bclk_o
);

  localparam int FRAME_MCLK = 2 * SLOTS * MCLK_PER_BIT;
  localparam int CNT_W      = $clog2(FRAME_MCLK);
  localparam int PH_W       = $clog2(MCLK_PER_BIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wclk_q, wclk_d;
  logic             bclk_q, bclk_d;
  logic [PH_W-1:0]  phase;
  logic             phase_hi;
  logic             stop;
  logic             data_slot;

  assign stop      = (fmt_i == FMT_STOP);
  assign phase     = cnt_q[PH_W-1:0];
  assign slot_o    = cnt_q[PH_W +: SLOT_W];
  assign half_o    = cnt_q[CNT_W-1];
  assign phase_hi  = (phase >= PH_W'(MCLK_PER_BIT / 2));
  assign data_slot = (int'(slot_o) < SAMPLE_W);

  assign frame_start_o = !stop && (cnt_q == '0);
  assign load_o        = stop || (cnt_q == CNT_W'(FRAME_MCLK - 1));

  // next-state
  always_comb begin
    cnt_d  = stop ? '0 : cnt_q + CNT_W'(1);
    wclk_d = !stop && !half_o;
    unique case (fmt_i)
      FMT_RJ:    bclk_d = phase_hi;
      FMT_LJ:    bclk_d = !phase_hi;
      FMT_GATED: bclk_d = !phase_hi && data_slot;
      default:   bclk_d = 1'b0;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wclk_q <= 1'b0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wclk_q <= wclk_d;
      bclk_q <= bclk_d;
    end
  end

  assign wclk_o = wclk_q;
  assign bclk_o = bclk_q;

  // R4: stop code silences both clocks on the following cycle
  p_clk_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_STOP) |=> (!wclk_o && !bclk_o));

  // R1: a bit clock high phase lasts at least two master cycles
  p_bclk_duty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bclk_o) && fmt_i != FMT_STOP) |=> bclk_o);

endmodule

// File: rtl/sfmt_store.sv
module sfmt_store #(
  parameter int N_CH     = 8,
  parameter int SAMPLE_W = 24,
  parameter int USER_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stb_i,
  input  logic [N_CH*SAMPLE_W-1:0] sample_i,
  input  logic [USER_W-1:0]        user_i,
  input  logic                     load_i,
  output logic [N_CH*SAMPLE_W-1:0] frame_o,
  output logic [USER_W-1:0]        frame_user_o
);

  localparam int BUS_W = N_CH * SAMPLE_W;

  logic [BUS_W-1:0]  hold_q, hold_d;
  logic [USER_W-1:0] hold_u_q, hold_u_d;
  logic [BUS_W-1:0]  shad_q, shad_d;
  logic [USER_W-1:0] shad_u_q, shad_u_d;
  logic              hold_en, shad_en;

  assign hold_en = stb_i;
  assign shad_en = load_i;

  always_comb begin
    hold_d   = stb_i ? sample_i : hold_q;
    hold_u_d = stb_i ? user_i   : hold_u_q;
    shad_d   = hold_d;
    shad_u_d = hold_u_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      hold_u_q <= '0;
    end else if (hold_en) begin
      hold_q   <= hold_d;
      hold_u_q <= hold_u_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shad_q   <= '0;
      shad_u_q <= '0;
    end else if (shad_en) begin
      shad_q   <= shad_d;
      shad_u_q <= shad_u_d;
    end
  end

  assign frame_o      = shad_q;
  assign frame_user_o = shad_u_q;

endmodule

// File: rtl/sfmt_lane.sv
module sfmt_lane
  import sfmt_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOTS    = 32,
  parameter int SLOT_W   = $clog2(SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_e                fmt_i,
  input  logic                mute_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                half_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sd_o
);

  localparam int PAD = SLOTS - SAMPLE_W;

  logic [SAMPLE_W-1:0] word;
  logic [SLOT_W-1:0]   lj_idx, rj_idx;
  logic                lj_bit, rj_bit, fmt_bit;
  logic                sd_q, sd_d;
  logic                quiet;

  assign word   = half_i ? right_i : left_i;
  assign lj_idx = SLOT_W'(SAMPLE_W - 1) - slot_i;
  assign rj_idx = SLOT_W'(SLOTS - 1) - slot_i;
  assign quiet  = mute_i || (fmt_i == FMT_STOP);

  always_comb begin
    lj_bit = (int'(slot_i) < SAMPLE_W) ? word[lj_idx] : 1'b0;
    rj_bit = (int'(slot_i) < PAD) ? word[SAMPLE_W-1] : word[rj_idx];
    fmt_bit = (fmt_i == FMT_RJ) ? rj_bit : lj_bit;
    sd_d = quiet ? 1'b0 : fmt_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sd_q <= 1'b0;
    else         sd_q <= sd_d;
  end

  assign sd_o = sd_q;

  // R8: mute clears the line on the next cycle
  p_mute_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |=> !sd_o);

  // R4: stop code clears the line on the next cycle
  p_data_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_STOP) |=> !sd_o);

endmodule

// File: rtl/sfmt_top.sv
module sfmt_top
  import sfmt_pkg::*;
#(
  parameter int CH_PAIRS     = 4,
  parameter int SAMPLE_W     = 24,
  parameter int SLOTS        = 32,
  parameter int MCLK_PER_BIT = 4,
  parameter int USER_W       = 4
) (
  input  logic                            mclk_i,
  input  logic                            rst_ni,
  input  logic                            frame_stb_i,
  input  logic [2*CH_PAIRS*SAMPLE_W-1:0]  sample_i,
  input  logic [USER_W-1:0]               user_i,
  input  logic [1:0]                      fmt_i,
  input  logic                            mute_i,
  output logic                            wclk_o,
  output logic                            bclk_o,
  output logic [CH_PAIRS-1:0]             sdata_o,
  output logic [USER_W-1:0]               user_o
);

  localparam int N_CH   = 2 * CH_PAIRS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BUS_W  = N_CH * SAMPLE_W;

  fmt_e              fmt;
  logic              rst_n;
  logic [SLOT_W-1:0] slot;
  logic              half;
  logic              frame_start;
  logic              load;
  logic [BUS_W-1:0]  frame_words;
  logic [USER_W-1:0] frame_user;
  logic [USER_W-1:0] user_q, user_d;
  logic              user_en;

  assign fmt = fmt_e'(fmt_i);

  sfmt_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (mclk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  sfmt_timing #(
    .SLOTS        (SLOTS),
    .MCLK_PER_BIT (MCLK_PER_BIT),
    .SAMPLE_W     (SAMPLE_W),
    .SLOT_W       (SLOT_W)
  ) u_timing (
    .clk_i         (mclk_i),
    .rst_ni        (rst_n),
    .fmt_i         (fmt),
    .slot_o        (slot),
    .half_o        (half),
    .frame_start_o (frame_start),
    .load_o        (load),
    .wclk_o        (wclk_o),
    .bclk_o        (bclk_o)
  );

  sfmt_store #(
    .N_CH     (N_CH),
    .SAMPLE_W (SAMPLE_W),
    .USER_W   (USER_W)
  ) u_store (
    .clk_i        (mclk_i),
    .rst_ni       (rst_n),
    .stb_i        (frame_stb_i),
    .sample_i     (sample_i),
    .user_i       (user_i),
    .load_i       (load),
    .frame_o      (frame_words),
    .frame_user_o (frame_user)
  );

  for (genvar k = 0; k < CH_PAIRS; k++) begin : g_lane
    sfmt_lane #(
      .SAMPLE_W (SAMPLE_W),
      .SLOTS    (SLOTS),
      .SLOT_W   (SLOT_W)
    ) u_lane (
      .clk_i   (mclk_i),
      .rst_ni  (rst_n),
      .fmt_i   (fmt),
      .mute_i  (mute_i),
      .slot_i  (slot),
      .half_i  (half),
      .left_i  (frame_words[(2*k)*SAMPLE_W +: SAMPLE_W]),
      .right_i (frame_words[(2*k+1)*SAMPLE_W +: SAMPLE_W]),
      .sd_o    (sdata_o[k])
    );
  end

  // user lines: refreshed with the frame start, cleared by the stop code
  assign user_en = frame_start || (fmt == FMT_STOP);

  always_comb begin
    user_d = (fmt == FMT_STOP) ? '0 : frame_user;
  end

  always_ff @(posedge mclk_i or negedge rst_n) begin
    if (!rst_n)       user_q <= '0;
    else if (user_en) user_q <= user_d;
  end

  assign user_o = user_q;

  // R10: user lines move only together with the rising word clock
  p_user_hold_r10: assert property (@(posedge mclk_i) disable iff (!rst_n)
    (!$rose(wclk_o) && $past(fmt_i) != 2'b10) |-> $stable(user_o));

endmodule

// File: tb/sfmt_top_test.sv
module sfmt_top_test;

  typedef struct {
    logic [191:0] s;
    logic [3:0]   u;
    logic [1:0]   f;
    logic         m;
  } exp_t;

  logic         mclk = 1'b0;
  logic         rst_n;
  logic         stb;
  logic [191:0] sample;
  logic [3:0]   user;
  logic [1:0]   fmt;
  logic         mute;
  logic         wclk, bclk;
  logic [3:0]   sdata;
  logic [3:0]   user_out;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];

  always #2 mclk = ~mclk;

  sfmt_top uut (
    .mclk_i      (mclk),
    .rst_ni      (rst_n),
    .frame_stb_i (stb),
    .sample_i    (sample),
    .user_i      (user),
    .fmt_i       (fmt),
    .mute_i      (mute),
    .wclk_o      (wclk),
    .bclk_o      (bclk),
    .sdata_o     (sdata),
    .user_o      (user_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [191:0] mk(input logic [23:0] base);
    logic [191:0] r;
    for (int i = 0; i < 8; i++) r[i*24 +: 24] = base ^ (24'h13579B * 24'(i + 1));
    return r;
  endfunction

  function automatic logic exp_bit(input logic [191:0] s, input int lane, input int hf,
                                   input int sl, input logic [1:0] f, input logic m);
    logic [23:0] w;
    w = s[(2*lane+hf)*24 +: 24];
    if (m || f == 2'b10) return 1'b0;
    if (f == 2'b00) return (sl < 8) ? w[23] : w[31-sl];
    return (sl < 24) ? w[23-sl] : 1'b0;
  endfunction

  function automatic logic exp_bclk(input logic [1:0] f, input int sl, input int ph);
    if (f == 2'b00) return (ph >= 2);
    if (f == 2'b01) return (ph < 2);
    if (f == 2'b11) return (ph < 2) && (sl < 24);
    return 1'b0;
  endfunction

  // driver: strobes data mid-frame, sets format and mute at the last cycle
  task automatic drive_frame(input bit wait_rise, input logic [191:0] s, input logic [3:0] u,
                             input logic [1:0] f, input logic m);
    exp_t e;
    if (wait_rise) begin
      @(posedge wclk);
      @(negedge mclk);
    end
    repeat (10) @(negedge mclk);
    stb = 1'b1; sample = s; user = u;
    @(negedge mclk);
    stb = 1'b0; sample = '0; user = '0;
    repeat (244) @(negedge mclk);
    fmt = f; mute = m;
    e.s = s; e.u = u; e.f = f; e.m = m;
    q.push_back(e);
  endtask

  // monitor: pops one expected frame per rising word clock
  initial begin
    bit at_start;
    exp_t e;
    at_start = 1'b0;
    forever begin
      if (!at_start) begin
        @(posedge wclk);
        @(negedge mclk);
      end
      at_start = 1'b0;
      if (q.size() != 0) begin
        e = q.pop_front();
        for (int i = 0; i < 256; i++) begin
          int k, hf, sl, ph;
          string dreq, breq;
          if (i != 0) @(negedge mclk);
          k = i / 4; hf = k / 32; sl = k % 32; ph = i % 4;
          dreq = e.m ? "R8" : (e.f == 2'b00) ? "R6 R9" : (e.f == 2'b11) ? "R7 R9" : "R5 R9";
          breq = (e.f == 2'b00) ? "R3" : (e.f == 2'b11) ? "R7" : (e.m ? "R8" : "R1");
          if (ph == 1) begin
            for (int ln = 0; ln < 4; ln++)
              chk(dreq, 32'(sdata[ln]), 32'(exp_bit(e.s, ln, hf, sl, e.f, e.m)));
            chk("R2", 32'(wclk), 32'(hf == 0));
            chk("R10", 32'(user_out), 32'(e.u));
          end
          if (ph == 1 || ph == 2)
            chk(breq, 32'(bclk), 32'(exp_bclk(e.f, sl, ph)));
        end
        @(negedge mclk);
        chk("R1", 32'(wclk), 32'd1);
        at_start = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge mclk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    exp_t e0;
    rst_n = 1'b0; fmt = 2'b10; mute = 1'b0; stb = 1'b0; sample = '0; user = '0;
    repeat (3) @(negedge mclk);
    // R11: reset state
    chk("R11", {28'd0, wclk, bclk, 2'd0}, 32'd0);
    chk("R11", 32'(sdata), 32'd0);
    chk("R11", 32'(user_out), 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge mclk);
    // R4: stop code holds everything low
    for (int i = 0; i < 40; i++) begin
      chk("R4", {30'd0, wclk, bclk}, 32'd0);
      chk("R4", {24'd0, sdata, user_out}, 32'd0);
      @(negedge mclk);
    end
    // captured while stopped, sent in the first frame after leaving the stop code
    e0.s = mk(24'h5A3C96); e0.u = 4'b1010; e0.f = 2'b01; e0.m = 1'b0;
    stb = 1'b1; sample = e0.s; user = e0.u;
    @(negedge mclk);
    stb = 1'b0; sample = '0; user = '0;
    @(negedge mclk);
    q.push_back(e0);
    fmt = 2'b01;
    @(negedge mclk);
    chk("R4", 32'(wclk), 32'd1);
    drive_frame(1'b0, mk(24'h123456), 4'b0101, 2'b00, 1'b0);  // next frame: right-justified
    drive_frame(1'b1, mk(24'h800F0F), 4'b0011, 2'b00, 1'b0);  // negative words
    drive_frame(1'b1, mk(24'hA1B2C3), 4'b1100, 2'b11, 1'b0);  // gated
    drive_frame(1'b1, mk(24'h7E7E01), 4'b1111, 2'b01, 1'b1);  // muted
    drive_frame(1'b1, mk(24'hC0FFEE), 4'b0110, 2'b01, 1'b0);  // back to normal
    repeat (300) @(negedge mclk);
    // R4: stop code applied in the middle of a frame
    @(posedge wclk);
    repeat (60) @(negedge mclk);
    fmt = 2'b10;
    @(negedge mclk);
    for (int i = 0; i < 8; i++) begin
      chk("R4", {30'd0, wclk, bclk}, 32'd0);
      chk("R4", {24'd0, sdata, user_out}, 32'd0);
      @(negedge mclk);
    end
    chk("R9", 32'(q.size()), 32'd0);
    finish_run();
  end

endmodule